// File: doc/BRIEF.md
# Double-Buffered PWM Channel with Fault Disconnect

This block turns a shared, externally generated 16-bit timer count and its period value into a pulse-width-modulated output. Software writes a pending duty value at any moment. The block copies that value into the duty register that drives the comparison only at the end of a PWM period. This means a running waveform never carries a half-updated pulse. The output rises at count zero and falls once the count reaches the active duty. A flag sets at every period end so that software can refill the pending duty.

A 3-bit mode code turns the channel on. With the fault-armed code, an active-low fault pin disconnects the output at once, through a path that needs no clock edge. It also records a sticky status and raises the flag. The output enable stands in for the tri-state control of a pad buffer. The timer itself and any register decoding live outside this block.

Top module: `pwm_fault_gen`

## Requirements
- R1: Mode code 3'b110 runs PWM with the fault pin ignored, and 3'b111 runs PWM with the fault pin armed. Any other code holds `pwm_out` low and `pwm_oe` low, and keeps loading the active duty from the pending duty (including a write in that same cycle).
- R2: A write on `duty_wr_en` updates the pending duty at the next clock edge. In PWM mode, the active duty takes the pending value at the edge that ends a cycle where `tmr_cnt == tmr_period`. A write presented in that same cycle is the value taken.
- R3: In PWM mode the active duty changes at no other edge, so a pending write shows no effect on the waveform before the next period end.
- R4: In PWM mode, `pwm_out` after a clock edge is 1 exactly when the `tmr_cnt` presented before that edge is below the active duty (before any update at that edge). The output is therefore high from count 0 until the count reaches the duty.
- R5: An active duty of 0 keeps `pwm_out` low at every count of the period. An active duty greater than `tmr_period` keeps it high at every count.
- R6: An active duty equal to `tmr_period` gives high for counts 0 to period-1 and low at the final count.
- R7: `irq_flag` is set by the edge ending a period-end cycle in PWM mode. It stays set until an edge with `flag_clr` high, and a set in the same cycle wins over the clear.
- R8: In mode 3'b111 a low `fault_n` drops `pwm_oe` combinationally, with no clock edge needed. The next edge sets `fault_status` and `irq_flag`.
- R9: `fault_status` and the disconnect stay in force after `fault_n` returns high, and after a mode change, until `rst_n` is asserted. In mode 3'b110 a low `fault_n` has no effect.
- R10: While `rst_n` is low, the outputs `pwm_out`, `fault_status` and `irq_flag` are 0, and both duty registers are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 3 | Channel mode code |
| tmr_cnt | input | 16 | Count of the selected timer |
| tmr_period | input | 16 | Period value of the selected timer |
| duty_wr_en | input | 1 | Write strobe for the pending duty |
| duty_wr_data | input | 16 | Pending duty value |
| fault_n | input | 1 | Active-low fault pin |
| flag_clr | input | 1 | Clears the interrupt flag |
| pwm_out | output | 1 | PWM level |
| pwm_oe | output | 1 | Output enable (low means disconnected) |
| fault_status | output | 1 | Sticky fault record |
| irq_flag | output | 1 | Period-end or fault flag |

## Verification
The registered results `pwm_out`, `irq_flag` and `fault_status` are due one edge after the count, write or fault that causes them. The bench therefore drives each vector at a falling edge and samples 1 ns after the following rising edge. A new duty shows in the level one edge after the period-end edge that loads it, and the vector table encodes this extra edge. `pwm_oe` is combinational, so the fault disconnect is checked with the clock held still: the sample is taken nanoseconds after `fault_n` falls, before any edge has occurred.

// File: rtl/pwm_fault_pkg.sv
package pwm_fault_pkg;

  localparam logic [2:0] MODE_PWM_FREE  = 3'b110;
  localparam logic [2:0] MODE_PWM_GUARD = 3'b111;

  // Both PWM codes share the two upper bits.
  function automatic logic mode_is_pwm(input logic [2:0] m);
    return (m == MODE_PWM_FREE) || (m == MODE_PWM_GUARD);
  endfunction

  function automatic logic mode_fault_armed(input logic [2:0] m);
    return m == MODE_PWM_GUARD;
  endfunction

endpackage

// File: rtl/pwm_duty_buf.sv
module pwm_duty_buf #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwm_on,
  input  logic             boundary,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] work_duty
);

  logic [CNT_W-1:0] pend_q;
  logic [CNT_W-1:0] pend_next;
  logic [CNT_W-1:0] work_q;
  logic             load_now;

  // A write in the boundary cycle is forwarded into the transfer.
  assign pend_next = wr_en ? wr_data : pend_q;
  // Outside PWM the active duty tracks the pending one (preload).
  assign load_now  = !pwm_on || boundary;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      work_q <= '0;
    end else begin
      pend_q <= pend_next;
      if (load_now) work_q <= pend_next;
    end
  end

  assign work_duty = work_q;

  p_hold_mid_period_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_on && !boundary) |=> $stable(work_duty));

  p_take_at_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && wr_en) |=> (work_duty == $past(wr_data)));

endmodule

// File: rtl/pwm_wave.sv
module pwm_wave #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwm_on,
  input  logic [CNT_W-1:0] tmr_cnt,
  input  logic [CNT_W-1:0] tmr_period,
  input  logic [CNT_W-1:0] work_duty,
  output logic             boundary,
  output logic             pwm_lvl
);

  function automatic logic at_period_end(input logic [CNT_W-1:0] cnt,
                                         input logic [CNT_W-1:0] per);
    return cnt == per;
  endfunction

  function automatic logic level_for(input logic [CNT_W-1:0] cnt,
                                     input logic [CNT_W-1:0] duty);
    return cnt < duty;
  endfunction

  logic lvl_d;

  assign boundary = pwm_on && at_period_end(tmr_cnt, tmr_period);
  assign lvl_d    = pwm_on && level_for(tmr_cnt, work_duty);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pwm_lvl <= 1'b0;
    else        pwm_lvl <= lvl_d;
  end

  p_zero_duty_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_on && work_duty == '0) |=> !pwm_lvl);

  p_over_duty_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_on && work_duty > tmr_period && tmr_cnt <= tmr_period) |=> pwm_lvl);

  p_idle_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !pwm_on |=> !pwm_lvl);

endmodule

// File: rtl/pwm_fault_guard.sv
module pwm_fault_guard
  import pwm_fault_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] mode,
  input  logic       fault_n,
  input  logic       pwm_on,
  output logic       fault_now,
  output logic       fault_event,
  output logic       sticky,
  output logic       oe
);

  logic sticky_q;

  assign fault_now   = mode_fault_armed(mode) && !fault_n;
  assign fault_event = fault_now && !sticky_q;
  // Disconnect needs no edge: the raw pin term is in the enable.
  assign oe          = pwm_on && !sticky_q && !fault_now;
  assign sticky      = sticky_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         sticky_q <= 1'b0;
    else if (fault_now) sticky_q <= 1'b1;
  end

  always_comb begin
    if (rst_n && !fault_n && mode == MODE_PWM_GUARD)
      a_pin_cuts_oe_r8: assert (!oe);
  end

  p_sticky_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sticky |=> sticky);

  p_fault_records_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fault_now |=> sticky);

endmodule

// File: rtl/pwm_irq_flag.sv
module pwm_irq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_period,
  input  logic set_fault,
  input  logic clr,
  output logic flag
);

  logic any_set;

  assign any_set = set_period || set_fault;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag <= 1'b0;
    else if (any_set) flag <= 1'b1;
    else if (clr)     flag <= 1'b0;
  end

  p_period_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
    set_period |=> flag);

  p_clear_drops_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set_period && !set_fault) |=> !flag);

  p_fault_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
    set_fault |=> flag);

endmodule

// File: rtl/pwm_fault_gen.sv
module pwm_fault_gen
  import pwm_fault_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       mode,
  input  logic [CNT_W-1:0] tmr_cnt,
  input  logic [CNT_W-1:0] tmr_period,
  input  logic             duty_wr_en,
  input  logic [CNT_W-1:0] duty_wr_data,
  input  logic             fault_n,
  input  logic             flag_clr,
  output logic             pwm_out,
  output logic             pwm_oe,
  output logic             fault_status,
  output logic             irq_flag
);

  logic             pwm_on;
  logic             boundary;
  logic [CNT_W-1:0] work_duty;
  logic             fault_now;
  logic             fault_event;

  assign pwm_on = mode_is_pwm(mode);

  pwm_duty_buf #(.CNT_W(CNT_W)) u_duty (
    .clk      (clk),
    .rst_n    (rst_n),
    .pwm_on   (pwm_on),
    .boundary (boundary),
    .wr_en    (duty_wr_en),
    .wr_data  (duty_wr_data),
    .work_duty(work_duty)
  );

  pwm_wave #(.CNT_W(CNT_W)) u_wave (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwm_on    (pwm_on),
    .tmr_cnt   (tmr_cnt),
    .tmr_period(tmr_period),
    .work_duty (work_duty),
    .boundary  (boundary),
    .pwm_lvl   (pwm_out)
  );

  pwm_fault_guard u_guard (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode       (mode),
    .fault_n    (fault_n),
    .pwm_on     (pwm_on),
    .fault_now  (fault_now),
    .fault_event(fault_event),
    .sticky     (fault_status),
    .oe         (pwm_oe)
  );

  pwm_irq_flag u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_period(boundary),
    .set_fault (fault_event),
    .clr       (flag_clr),
    .flag      (irq_flag)
  );

  p_free_mode_ignores_pin_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_PWM_FREE && !fault_status) |=> (fault_status == 1'b0));

  p_status_cuts_oe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fault_status |-> !pwm_oe);

endmodule

// File: tb/test_pwm_fault_gen.sv
module test_pwm_fault_gen;

  typedef struct packed {
    logic [2:0]  m;
    logic [15:0] c;
    logic [15:0] p;
    logic        we;
    logic [15:0] wd;
    logic        fn;
    logic        clr;
    logic        e_out;
    logic        e_oe;
    logic        e_flt;
    logic        e_irq;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 24;
  // Period value 4 throughout; comments name the requirement each row targets.
  localparam vec_t VEC [NV] = '{
    '{3'd0,16'd0,16'd4,1'b1,16'd3,1'b1,1'b0, 1'b0,1'b0,1'b0,1'b0, 8'd1}, // R1 preload 3
    '{3'd6,16'd0,16'd4,1'b0,16'd0,1'b1,1'b0, 1'b1,1'b1,1'b0,1'b0, 8'd4}, // R4
    '{3'd6,16'd1,16'd4,1'b0,16'd0,1'b1,1'b0, 1'b1,1'b1,1'b0,1'b0, 8'd4}, // R4
    '{3'd6,16'd2,16'd4,1'b1,16'd1,1'b1,1'b0, 1'b1,1'b1,1'b0,1'b0, 8'd3}, // R3 pend 1
    '{3'd6,16'd3,16'd4,1'b0,16'd0,1'b1,1'b0, 1'b0,1'b1,1'b0,1'b0, 8'd4}, // R4 falls at duty
    '{3'd6,16'd4,16'd4,1'b0,16'd0,1'b1,1'b0, 1'b0,1'b1,1'b0,1'b1, 8'd7}, // R7 end sets flag
    '{3'd6,16'd0,16'd4,1'b0,16'd0,1'b1,1'b0, 1'b1,1'b1,1'b0,1'b1, 8'd2}, // R2 duty 1 now
    '{3'd6,16'd1,16'd4,1'b0,16'd0,1'b1,1'b1, 1'b0,1'b1,1'b0,1'b0, 8'd7}, // R7 clear
    '{3'd6,16'd2,16'd4,1'b0,16'd0,1'b1,1'b0, 1'b0,1'b1,1'b0,1'b0, 8'd3},
    '{3'd6,16'd3,16'd4,1'b1,16'd0,1'b1,1'b0, 1'b0,1'b1,1'b0,1'b0, 8'd3}, // R3 pend 0
    '{3'd6,16'd4,16'd4,1'b0,16'd0,1'b1,1'b0, 1'b0,1'b1,1'b0,1'b1, 8'd2}, // R2 duty 0
    '{3'd6,16'd0,16'd4,1'b0,16'd0,1'b1,1'b1, 1'b0,1'b1,1'b0,1'b0, 8'd5}, // R5 zero duty
    '{3'd6,16'd4,16'd4,1'b1,16'd5,1'b1,1'b0, 1'b0,1'b1,1'b0,1'b1, 8'd2}, // R2 same-cycle write
    '{3'd6,16'd0,16'd4,1'b0,16'd0,1'b1,1'b0, 1'b1,1'b1,1'b0,1'b1, 8'd5}, // R5 over period
    '{3'd6,16'd4,16'd4,1'b0,16'd0,1'b1,1'b0, 1'b1,1'b1,1'b0,1'b1, 8'd5}, // R5 high at last count
    '{3'd6,16'd2,16'd4,1'b1,16'd4,1'b1,1'b1, 1'b1,1'b1,1'b0,1'b0, 8'd3}, // R3 pend 4
    '{3'd6,16'd4,16'd4,1'b0,16'd0,1'b1,1'b1, 1'b1,1'b1,1'b0,1'b1, 8'd7}, // R7 set wins
    '{3'd6,16'd0,16'd4,1'b0,16'd0,1'b1,1'b0, 1'b1,1'b1,1'b0,1'b1, 8'd6}, // R6
    '{3'd6,16'd3,16'd4,1'b0,16'd0,1'b1,1'b0, 1'b1,1'b1,1'b0,1'b1, 8'd6}, // R6
    '{3'd6,16'd4,16'd4,1'b0,16'd0,1'b1,1'b0, 1'b0,1'b1,1'b0,1'b1, 8'd6}, // R6 low at last
    '{3'd6,16'd0,16'd4,1'b0,16'd0,1'b0,1'b0, 1'b1,1'b1,1'b0,1'b1, 8'd9}, // R9 free mode
    '{3'd3,16'd1,16'd4,1'b1,16'd2,1'b1,1'b0, 1'b0,1'b0,1'b0,1'b1, 8'd1}, // R1 other code
    '{3'd6,16'd1,16'd4,1'b0,16'd0,1'b1,1'b0, 1'b1,1'b1,1'b0,1'b1, 8'd1}, // R1 preload 2
    '{3'd6,16'd2,16'd4,1'b0,16'd0,1'b1,1'b1, 1'b0,1'b1,1'b0,1'b0, 8'd1}
  };

  logic        clk = 1'b0;
  logic        clk_run = 1'b1;
  logic        rst_n;
  logic [2:0]  mode;
  logic [15:0] tmr_cnt, tmr_period, duty_wr_data;
  logic        duty_wr_en, fault_n, flag_clr;
  logic        pwm_out, pwm_oe, fault_status, irq_flag;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  initial forever begin
    #5;
    if (clk_run) clk = ~clk;
  end

  pwm_fault_gen i_pwm_fault_gen (
    .clk(clk), .rst_n(rst_n), .mode(mode), .tmr_cnt(tmr_cnt),
    .tmr_period(tmr_period), .duty_wr_en(duty_wr_en),
    .duty_wr_data(duty_wr_data), .fault_n(fault_n), .flag_clr(flag_clr),
    .pwm_out(pwm_out), .pwm_oe(pwm_oe), .fault_status(fault_status),
    .irq_flag(irq_flag)
  );

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: {out,oe,flt,irq} actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [3:0] outs();
    return {pwm_out, pwm_oe, fault_status, irq_flag};
  endfunction

  initial begin
    #1_000_000;
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; mode = 3'd0; tmr_cnt = '0; tmr_period = 16'd4;
    duty_wr_en = 1'b0; duty_wr_data = '0; fault_n = 1'b1; flag_clr = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R10", outs(), 4'b0000);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      mode = VEC[i].m; tmr_cnt = VEC[i].c; tmr_period = VEC[i].p;
      duty_wr_en = VEC[i].we; duty_wr_data = VEC[i].wd;
      fault_n = VEC[i].fn; flag_clr = VEC[i].clr;
      @(posedge clk);
      #1;
      check($sformatf("R%0d row %0d", VEC[i].req, i), outs(),
            {VEC[i].e_out, VEC[i].e_oe, VEC[i].e_flt, VEC[i].e_irq});
    end

    // R8: arm the fault mode, then drop the pin with the clock stopped.
    @(negedge clk);
    mode = 3'b111; tmr_cnt = 16'd1; duty_wr_en = 1'b0; fault_n = 1'b1; flag_clr = 1'b0;
    @(posedge clk); #1;
    check("R8 armed", outs(), 4'b1100);
    @(negedge clk);
    clk_run = 1'b0;
    #20;
    fault_n = 1'b0;
    #3;
    check("R8 no-edge disconnect", outs(), 4'b1000);
    clk_run = 1'b1;
    @(posedge clk); #1;
    check("R8 status and flag", outs(), 4'b1011);
    @(negedge clk);
    fault_n = 1'b1; flag_clr = 1'b1;
    @(posedge clk); #1;
    check("R9 sticky after pin release", outs(), 4'b1010);
    @(negedge clk);
    mode = 3'b110; flag_clr = 1'b0;
    @(posedge clk); #1;
    check("R9 sticky after mode change", outs(), 4'b1010);

    // R10: reset clears status and both duty registers.
    @(negedge clk);
    mode = 3'd0; rst_n = 1'b0;
    #3;
    check("R10 async reset", outs(), 4'b0000);
    @(negedge clk);
    rst_n = 1'b1; mode = 3'b110; tmr_cnt = 16'd0;
    @(posedge clk); #1;
    check("R10 duty zero after reset", outs(), 4'b0100);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule